// File: doc/BRIEF.md
# Weighted Two-Master Bus Arbiter

This block decides which of two masters owns a shared peripheral bus: a processor memory port or a DMA engine. A 3-bit weight register sets the policy. A weight of zero gives the processor strict priority. A weight of n, from 1 to 7, hands priority to the DMA engine, which may then complete n back-to-back accesses before the processor must be served. The bus side reports the end of each access with a one-cycle completion pulse. Ownership only moves on that pulse, or while the bus is idle.

Grants are registered. While no master owns the bus, the arbiter makes a decision on every clock. While a master owns the bus, it decides only in the cycle in which the completion pulse arrives. A DMA credit counter tracks how many accesses the DMA may still take. It is refilled from the weight register whenever the processor is granted. It is also refilled when the credit runs out while the processor is not asking for the bus. A write to the weight register also loads the credit, so the new value governs the next decision.

Top module: `periph_bus_arbiter`

## Requirements
- R1: After reset neither grant is asserted and the weight register is 0, so a simultaneous request from both masters is granted to the processor.
- R2: The two grant outputs are never high at the same time.
- R3: When the bus is idle, a request is answered by a grant on the clock edge after the one at which the request is first sampled; the grant is not visible in the cycle the request is raised.
- R4: While a grant is held and the completion pulse is low, both grant outputs stay unchanged, even if requests change.
- R5: When only one master requests at a decision, that master is granted whatever the weight value.
- R6: With weight 0 and both masters requesting at a decision, the processor is granted.
- R7: With weight n in 1..7 and both masters requesting continuously, the DMA engine is granted for exactly n consecutive accesses and then the processor for one access, and the pattern repeats.
- R8: Granting the processor refills the DMA credit to n, so after each processor access the DMA again receives n accesses.
- R9: If the DMA credit reaches zero at a decision where the processor is not requesting, the credit is refilled to n; a processor request raised later must wait for n further DMA accesses.
- R10: A write (write strobe high, 3-bit value) sets the weight and the DMA credit to the written value; if it happens during a DMA access, the next decision already uses the written credit.
- R11: At a decision with no request from either master, both grants go low at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor requests the bus |
| dmaReq | input | 1 | DMA engine requests the bus |
| accDone | input | 1 | One-cycle pulse marking the end of the current access |
| cfgWrEn | input | 1 | Write strobe for the weight register |
| cfgWrData | input | 3 | Weight value to write (0 = processor priority, n = DMA burst of n) |
| cpuGnt | output | 1 | Bus granted to the processor |
| dmaGnt | output | 1 | Bus granted to the DMA engine |

## Verification
Every grant is due exactly one edge after the cycle in which the decision is made. That cycle is either an idle cycle in which requests are seen, or the cycle carrying the completion pulse. The bench drives inputs one time unit after a rising edge. It reads the grants after the following edge, so each check falls in the first cycle in which a new owner can appear. A weight write takes one edge to land. The bench performs it in a cycle with no decision, or during an access, and then checks the owner chosen at the next completion pulse. Hold checks read the grants over several cycles with the completion pulse low, and expect no change.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // strobes from the grant control to the credit datapath
  typedef struct packed {
    logic consume;  // a DMA access finishes this cycle
    logic reload;   // refill credit from the weight register
  } creditCtl_t;
endpackage

// File: rtl/arb_credit_path.sv
module arb_credit_path
  import arb_pkg::*;
#(
  parameter int ALLOC_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ALLOC_W-1:0] cfgWrData,
  input  creditCtl_t         ctl,
  output logic               allocZero,
  output logic               creditEmpty,
  output logic [ALLOC_W-1:0] allocVal
);
  localparam logic [ALLOC_W-1:0] ZERO = '0;
  localparam logic [ALLOC_W-1:0] ONE  = ALLOC_W'(1);

  logic [ALLOC_W-1:0] allocReg;
  logic [ALLOC_W-1:0] creditCnt;
  logic [ALLOC_W-1:0] creditLeft;

  // credit as seen by a decision in this cycle
  always_comb begin
    if (ctl.consume && creditCnt != ZERO) creditLeft = creditCnt - ONE;
    else                                  creditLeft = creditCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allocReg  <= ZERO;
      creditCnt <= ZERO;
    end else if (cfgWrEn) begin
      allocReg  <= cfgWrData;
      creditCnt <= cfgWrData;
    end else if (ctl.reload) begin
      creditCnt <= allocReg;
    end else begin
      creditCnt <= creditLeft;
    end
  end

  assign allocZero   = (allocReg == ZERO);
  assign creditEmpty = (creditLeft == ZERO);
  assign allocVal    = allocReg;
endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       dmaReq,
  input  logic       accDone,
  input  logic       allocZero,
  input  logic       creditEmpty,
  output logic       cpuGnt,
  output logic       dmaGnt,
  output creditCtl_t ctl
);
  logic busy;
  logic decide;
  logic pickCpu;
  logic pickDma;

  assign busy   = cpuGnt | dmaGnt;
  assign decide = !busy | accDone;

  // processor wins unless the DMA holds priority and still has credit
  assign pickCpu = cpuReq & (!dmaReq | allocZero | creditEmpty);
  assign pickDma = dmaReq & !pickCpu;

  always_comb begin
    ctl.consume = accDone & dmaGnt;
    ctl.reload  = decide & (pickCpu | (creditEmpty & !cpuReq));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuGnt <= 1'b0;
      dmaGnt <= 1'b0;
    end else if (decide) begin
      cpuGnt <= pickCpu;
      dmaGnt <= pickDma;
    end
  end
endmodule

// File: rtl/periph_bus_arbiter.sv
module periph_bus_arbiter
  import arb_pkg::*;
#(
  parameter int ALLOC_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuReq,
  input  logic               dmaReq,
  input  logic               accDone,
  input  logic               cfgWrEn,
  input  logic [ALLOC_W-1:0] cfgWrData,
  output logic               cpuGnt,
  output logic               dmaGnt
);
  creditCtl_t         ctl;
  logic               allocZero;
  logic               creditEmpty;
  logic [ALLOC_W-1:0] allocVal;

  arb_grant_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReq      (cpuReq),
    .dmaReq      (dmaReq),
    .accDone     (accDone),
    .allocZero   (allocZero),
    .creditEmpty (creditEmpty),
    .cpuGnt      (cpuGnt),
    .dmaGnt      (dmaGnt),
    .ctl         (ctl)
  );

  arb_credit_path #(.ALLOC_W(ALLOC_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .ctl         (ctl),
    .allocZero   (allocZero),
    .creditEmpty (creditEmpty),
    .allocVal    (allocVal)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int ALLOC_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuReq,
  input logic               dmaReq,
  input logic               accDone,
  input logic               cpuGnt,
  input logic               dmaGnt,
  input logic [ALLOC_W-1:0] allocVal
);
  logic decisionCyc;
  assign decisionCyc = !(cpuGnt || dmaGnt) || accDone;

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuGnt && dmaGnt));

  // R4
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuGnt || dmaGnt) && !accDone) |=> ($stable(cpuGnt) && $stable(dmaGnt)));

  // R5
  lone_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionCyc && cpuReq && !dmaReq) |=> cpuGnt);

  // R5
  lone_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionCyc && dmaReq && !cpuReq) |=> dmaGnt);

  // R6
  strict_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionCyc && cpuReq && allocVal == '0) |=> cpuGnt);

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionCyc && !cpuReq && !dmaReq) |=> (!cpuGnt && !dmaGnt));
endmodule

bind periph_bus_arbiter arb_checker #(.ALLOC_W(ALLOC_W)) u_arb_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .dmaReq   (dmaReq),
  .accDone  (accDone),
  .cpuGnt   (cpuGnt),
  .dmaGnt   (dmaGnt),
  .allocVal (allocVal)
);

// File: tb/test_periph_bus_arbiter.sv
`timescale 1ns/1ps
module test_periph_bus_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuReq = 1'b0;
  logic       dmaReq = 1'b0;
  logic       accDone = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgWrData = 3'd0;
  logic       cpuGnt;
  logic       dmaGnt;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  periph_bus_arbiter i_periph_bus_arbiter (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .dmaReq    (dmaReq),
    .accDone   (accDone),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cpuGnt    (cpuGnt),
    .dmaGnt    (dmaGnt)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsFailed++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
      summary();
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // compare {cpuGnt,dmaGnt} against expectation
  task automatic checkGnt(input string req, input logic expCpu, input logic expDma);
    testsRun++;
    if (cpuGnt !== expCpu || dmaGnt !== expDma) begin
      testsFailed++;
      $display("FAIL %s: actual cpuGnt=%b dmaGnt=%b expected cpuGnt=%b dmaGnt=%b",
               req, cpuGnt, dmaGnt, expCpu, expDma);
    end
  endtask

  task automatic pulseDone();
    accDone = 1'b1;
    step();
    accDone = 1'b0;
  endtask

  task automatic writeWeight(input logic [2:0] val);
    cfgWrEn = 1'b1;
    cfgWrData = val;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic goIdle();
    cpuReq = 1'b0;
    dmaReq = 1'b0;
    if (cpuGnt || dmaGnt) pulseDone();
    step();
  endtask

  // R1: reset state and default strict processor priority
  task automatic testReset();
    #1;
    checkGnt("R1 in reset", 1'b0, 1'b0);
    step();
    rstN = 1'b1;
    step();
    checkGnt("R1 after reset", 1'b0, 1'b0);
    cpuReq = 1'b1;
    dmaReq = 1'b1;
    step();
    checkGnt("R1 default weight favours cpu", 1'b1, 1'b0);
    goIdle();
  endtask

  // R6 and R11
  task automatic testStrict();
    cpuReq = 1'b1;
    dmaReq = 1'b1;
    step();
    for (int i = 0; i < 3; i++) begin
      checkGnt("R6 weight 0 both requesting", 1'b1, 1'b0);
      pulseDone();
    end
    cpuReq = 1'b0;
    dmaReq = 1'b0;
    pulseDone();
    checkGnt("R11 no request releases bus", 1'b0, 1'b0);
  endtask

  // R3 and R5
  task automatic testSingle();
    writeWeight(3'd0);
    dmaReq = 1'b1;
    checkGnt("R3 no grant in request cycle", 1'b0, 1'b0);
    step();
    checkGnt("R3/R5 lone dma granted with weight 0", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R5 lone dma regranted", 1'b0, 1'b1);
    goIdle();
    writeWeight(3'd5);
    cpuReq = 1'b1;
    step();
    checkGnt("R5 lone cpu granted with weight 5", 1'b1, 1'b0);
    goIdle();
  endtask

  // R4 and R2
  task automatic testHold();
    writeWeight(3'd0);
    cpuReq = 1'b1;
    step();
    checkGnt("R4 cpu owns bus", 1'b1, 1'b0);
    cpuReq = 1'b0;
    dmaReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      checkGnt("R4 grant held without done", 1'b1, 1'b0);
    end
    pulseDone();
    checkGnt("R4/R2 handover at done", 1'b0, 1'b1);
    goIdle();
  endtask

  // R7 and R8: n dma accesses, one cpu, repeated twice
  task automatic testWeighted(input logic [2:0] n);
    writeWeight(n);
    cpuReq = 1'b1;
    dmaReq = 1'b1;
    step();
    for (int round = 0; round < 2; round++) begin
      for (int k = 0; k < int'(n); k++) begin
        checkGnt(round == 0 ? "R7 dma burst" : "R8 dma burst after cpu refill",
                 1'b0, 1'b1);
        pulseDone();
      end
      checkGnt("R7 cpu after burst", 1'b1, 1'b0);
      pulseDone();
    end
    goIdle();
  endtask

  // R9: credit runs out while cpu idle, refill applies
  task automatic testRefillIdle();
    writeWeight(3'd2);
    dmaReq = 1'b1;
    step();
    checkGnt("R9 dma access 1", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R9 dma access 2", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R9 dma access 3 after refill", 1'b0, 1'b1);
    cpuReq = 1'b1;
    pulseDone();
    checkGnt("R9 refilled credit keeps dma", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R9 cpu after refilled credit", 1'b1, 1'b0);
    goIdle();
  endtask

  // R10: write during a dma burst
  task automatic testWriteMid();
    writeWeight(3'd7);
    cpuReq = 1'b1;
    dmaReq = 1'b1;
    step();
    checkGnt("R10 dma wins with weight 7", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R10 dma second access", 1'b0, 1'b1);
    writeWeight(3'd1);
    checkGnt("R10 write does not move grant", 1'b0, 1'b1);
    pulseDone();
    checkGnt("R10 written credit 1 used", 1'b1, 1'b0);
    pulseDone();
    checkGnt("R10 weight 1 gives dma one access", 1'b0, 1'b1);
    writeWeight(3'd0);
    pulseDone();
    checkGnt("R10 weight 0 written mid access", 1'b1, 1'b0);
    goIdle();
  endtask

  initial begin
    testReset();
    testStrict();
    testSingle();
    testHold();
    testWeighted(3'd1);
    testWeighted(3'd3);
    testWeighted(3'd7);
    testRefillIdle();
    testWriteMid();
    summary();
  end
endmodule